// File: doc/BRIEF.md
# Twin-Predicated Compress/Expand Mover

This block sequences a single-source, single-destination vector operation, such as a register move, under two independent predicates. One predicate guards the source elements and the other guards the destination slots. After a start strobe it walks a source index and a destination index. Each index skips past the clear bits of its own mask. For every matched pair the block issues one move, carrying both element indices and the register numbers formed from the two base registers, to a register-file model.

Each side carries a vector/scalar tag, and the masks can be full or hold a single bit. Together these give compress, expand, splat, select and insert from the one walk. Each skip is resolved in a single cycle by a priority scan of the unvisited part of the mask, so the sequencer issues at most one move per cycle and a run of clear bits costs no extra cycles. A one-cycle done pulse closes each operation and reports how many moves were issued.

Top module: `twin_pred_mover`

## Requirements
- R1: After reset, `busy`, `moveValid` and `done` are low and `moveCount` is zero.
- R2: A `start` while idle latches the length, both masks, both bases and both tags, and raises `busy`. The length is clamped to MAX_VL. A `start` while busy is ignored, and the running operation completes with its originally latched inputs.
- R3: Both indices start at 0. A vector-tagged side first advances its index to the lowest set bit of its mask at or above the current index. A scalar-tagged side keeps its index without looking at its mask. Bit k of each mask belongs to element k.
- R4: A move is issued only when both candidate indices are below the latched length. Otherwise the operation ends without a move for that step.
- R5: After a move, the index of each vector side becomes the moved index plus one, and the index of each scalar side stays unchanged.
- R6: With a scalar destination, the operation ends right after its first move. `done` rises in the same cycle as that move.
- R7: Moves are issued in increasing index order, at most one per cycle. `moveSrcReg` equals the source base plus `moveSrcIdx`, and `moveDstReg` equals the destination base plus `moveDstIdx`, both modulo 2^REG_W.
- R8: `done` is a one-cycle pulse and `busy` is low while it is high. `moveCount` then equals the number of moves issued by that operation.
- R9: A length of zero, or an all-zero mask on a vector-tagged side, ends the operation with no move and a count of zero.
- R10: With both sides vector-tagged, an all-ones destination mask packs the active source elements into slots 0, 1, 2 and so on (compress). An all-ones source mask spreads elements 0, 1, 2 and so on into the active destination slots (expand).
- R11: A scalar source with a vector destination writes element 0 of the source into every active destination slot: splat with several set bits, insert with a single set bit. A vector source with a scalar destination moves the lowest active source element into slot 0 (select).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| vlIn | input | IDX_W | Requested vector length |
| srcMask | input | MAX_VL | Source predicate, bit k for element k |
| dstMask | input | MAX_VL | Destination predicate, bit k for slot k |
| srcBase | input | REG_W | Source base register number |
| dstBase | input | REG_W | Destination base register number |
| srcIsVec | input | 1 | Source is vector-tagged |
| dstIsVec | input | 1 | Destination is vector-tagged |
| busy | output | 1 | Operation in progress |
| moveValid | output | 1 | A move is presented this cycle |
| moveSrcIdx | output | IDX_W | Source element index of the move |
| moveDstIdx | output | IDX_W | Destination element index of the move |
| moveSrcReg | output | REG_W | Source register number of the move |
| moveDstReg | output | REG_W | Destination register number of the move |
| done | output | 1 | One-cycle completion pulse |
| moveCount | output | IDX_W | Moves issued by the current or last operation |

## Verification
A sparse source mask against a full destination mask, and the reverse, separates compress from expand. These cases show whether each index skips only on its own mask. Splat, insert and select use scalar tags with single-bit or full masks. They expose whether a scalar side is wrongly stepped, or its mask wrongly consulted, and whether a scalar destination stops after one move. Uneven masks with different populations check that the walk stops when the first side runs out. A zero length, an empty mask, an oversized length and a start during a running operation probe the termination, clamp and ignore rules.

// File: rtl/twin_pred_pkg.sv
package twin_pred_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctrlStrobes_t;
endpackage

// File: rtl/tpm_prio_scan.sv
module tpm_prio_scan #(
  parameter int WIDTH = 16,
  parameter int IDX_W = 5
) (
  input  logic [WIDTH-1:0] mask,
  input  logic [IDX_W-1:0] fromIdx,
  output logic             found,
  output logic [IDX_W-1:0] pos
);
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int k = WIDTH - 1; k >= 0; k--) begin
      if (mask[k] && (IDX_W'(k) >= fromIdx)) begin
        found = 1'b1;
        pos   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/tpm_datapath.sv
module tpm_datapath
  import twin_pred_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int REG_W  = 7,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  vlIn,
  input  logic [MAX_VL-1:0] srcMask,
  input  logic [MAX_VL-1:0] dstMask,
  input  logic [REG_W-1:0]  srcBase,
  input  logic [REG_W-1:0]  dstBase,
  input  logic              srcIsVec,
  input  logic              dstIsVec,
  output logic              canMove,
  output logic              dstVecNow,
  output logic              moveValid,
  output logic [IDX_W-1:0]  moveSrcIdx,
  output logic [IDX_W-1:0]  moveDstIdx,
  output logic [REG_W-1:0]  moveSrcReg,
  output logic [REG_W-1:0]  moveDstReg,
  output logic              done,
  output logic [IDX_W-1:0]  moveCount
);
  localparam logic [IDX_W-1:0] VL_CAP = IDX_W'(MAX_VL);

  logic [IDX_W-1:0]  vlReg, idxSrc, idxDst;
  logic [MAX_VL-1:0] sMaskReg, dMaskReg;
  logic [REG_W-1:0]  sBaseReg, dBaseReg;
  logic              sVecReg, dVecReg;

  logic [IDX_W-1:0] vlClamped;
  logic [IDX_W-1:0] scanPos [2];
  logic             scanFound [2];
  logic [MAX_VL-1:0] scanMask [2];
  logic [IDX_W-1:0] scanFrom [2];
  logic [IDX_W-1:0] candSrc, candDst;
  logic             okSrc, okDst;

  assign vlClamped = (vlIn > VL_CAP) ? VL_CAP : vlIn;

  assign scanMask[0] = sMaskReg;
  assign scanMask[1] = dMaskReg;
  assign scanFrom[0] = idxSrc;
  assign scanFrom[1] = idxDst;

  for (genvar g = 0; g < 2; g++) begin : gScan
    tpm_prio_scan #(.WIDTH(MAX_VL), .IDX_W(IDX_W)) uScan (
      .mask   (scanMask[g]),
      .fromIdx(scanFrom[g]),
      .found  (scanFound[g]),
      .pos    (scanPos[g])
    );
  end

  always_comb begin
    candSrc = sVecReg ? scanPos[0] : idxSrc;
    candDst = dVecReg ? scanPos[1] : idxDst;
    okSrc   = (!sVecReg || scanFound[0]) && (candSrc < vlReg);
    okDst   = (!dVecReg || scanFound[1]) && (candDst < vlReg);
  end

  assign canMove   = okSrc && okDst;
  assign dstVecNow = dVecReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlReg      <= '0;
      idxSrc     <= '0;
      idxDst     <= '0;
      sMaskReg   <= '0;
      dMaskReg   <= '0;
      sBaseReg   <= '0;
      dBaseReg   <= '0;
      sVecReg    <= 1'b0;
      dVecReg    <= 1'b0;
      moveValid  <= 1'b0;
      moveSrcIdx <= '0;
      moveDstIdx <= '0;
      moveSrcReg <= '0;
      moveDstReg <= '0;
      done       <= 1'b0;
      moveCount  <= '0;
    end else begin
      moveValid <= 1'b0;
      done      <= 1'b0;
      if (strobes.load) begin
        vlReg     <= vlClamped;
        sMaskReg  <= srcMask;
        dMaskReg  <= dstMask;
        sBaseReg  <= srcBase;
        dBaseReg  <= dstBase;
        sVecReg   <= srcIsVec;
        dVecReg   <= dstIsVec;
        idxSrc    <= '0;
        idxDst    <= '0;
        moveCount <= '0;
      end
      if (strobes.step) begin
        moveValid  <= 1'b1;
        moveSrcIdx <= candSrc;
        moveDstIdx <= candDst;
        moveSrcReg <= sBaseReg + REG_W'(candSrc);
        moveDstReg <= dBaseReg + REG_W'(candDst);
        idxSrc     <= sVecReg ? candSrc + 1'b1 : candSrc;
        idxDst     <= dVecReg ? candDst + 1'b1 : candDst;
        moveCount  <= moveCount + 1'b1;
      end
      if (strobes.finish) begin
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tpm_ctrl.sv
module tpm_ctrl
  import twin_pred_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         canMove,
  input  logic         dstVecNow,
  output ctrlStrobes_t strobes,
  output logic         busy
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          stateNext    = ST_RUN;
        end
      end
      ST_RUN: begin
        if (canMove) begin
          strobes.step = 1'b1;
          if (!dstVecNow) begin
            strobes.finish = 1'b1;
            stateNext      = ST_IDLE;
          end
        end else begin
          strobes.finish = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover
  import twin_pred_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int REG_W  = 7,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  vlIn,
  input  logic [MAX_VL-1:0] srcMask,
  input  logic [MAX_VL-1:0] dstMask,
  input  logic [REG_W-1:0]  srcBase,
  input  logic [REG_W-1:0]  dstBase,
  input  logic              srcIsVec,
  input  logic              dstIsVec,
  output logic              busy,
  output logic              moveValid,
  output logic [IDX_W-1:0]  moveSrcIdx,
  output logic [IDX_W-1:0]  moveDstIdx,
  output logic [REG_W-1:0]  moveSrcReg,
  output logic [REG_W-1:0]  moveDstReg,
  output logic              done,
  output logic [IDX_W-1:0]  moveCount
);
  ctrlStrobes_t strobes;
  logic canMove, dstVecNow;

  tpm_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .canMove  (canMove),
    .dstVecNow(dstVecNow),
    .strobes  (strobes),
    .busy     (busy)
  );

  tpm_datapath #(.MAX_VL(MAX_VL), .REG_W(REG_W), .IDX_W(IDX_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .vlIn      (vlIn),
    .srcMask   (srcMask),
    .dstMask   (dstMask),
    .srcBase   (srcBase),
    .dstBase   (dstBase),
    .srcIsVec  (srcIsVec),
    .dstIsVec  (dstIsVec),
    .canMove   (canMove),
    .dstVecNow (dstVecNow),
    .moveValid (moveValid),
    .moveSrcIdx(moveSrcIdx),
    .moveDstIdx(moveDstIdx),
    .moveSrcReg(moveSrcReg),
    .moveDstReg(moveDstReg),
    .done      (done),
    .moveCount (moveCount)
  );
endmodule

// File: rtl/twin_pred_mover_chk.sv
module twin_pred_mover_chk #(
  parameter int MAX_VL = 16,
  parameter int REG_W  = 7,
  parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [IDX_W-1:0]  vlIn,
  input logic [MAX_VL-1:0] srcMask,
  input logic [MAX_VL-1:0] dstMask,
  input logic [REG_W-1:0]  srcBase,
  input logic [REG_W-1:0]  dstBase,
  input logic              srcIsVec,
  input logic              dstIsVec,
  input logic              busy,
  input logic              moveValid,
  input logic [IDX_W-1:0]  moveSrcIdx,
  input logic [IDX_W-1:0]  moveDstIdx,
  input logic [REG_W-1:0]  moveSrcReg,
  input logic [REG_W-1:0]  moveDstReg,
  input logic              done,
  input logic [IDX_W-1:0]  moveCount
);
  logic [IDX_W-1:0]  cVl;
  logic [MAX_VL-1:0] cSMask, cDMask;
  logic [REG_W-1:0]  cSBase, cDBase;
  logic              cSVec, cDVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cVl <= '0; cSMask <= '0; cDMask <= '0;
      cSBase <= '0; cDBase <= '0; cSVec <= 1'b0; cDVec <= 1'b0;
    end else if (start && !busy) begin
      cVl    <= (vlIn > IDX_W'(MAX_VL)) ? IDX_W'(MAX_VL) : vlIn;
      cSMask <= srcMask;
      cDMask <= dstMask;
      cSBase <= srcBase;
      cDBase <= dstBase;
      cSVec  <= srcIsVec;
      cDVec  <= dstIsVec;
    end
  end

  AST_MOVE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    moveValid |-> (moveSrcIdx < cVl) && (moveDstIdx < cVl)); // R4
  AST_SRC_BIT_SET: assert property (@(posedge clk) disable iff (!rstN)
    moveValid && cSVec |-> ((cSMask >> moveSrcIdx) & MAX_VL'(1)) != '0); // R3
  AST_DST_BIT_SET: assert property (@(posedge clk) disable iff (!rstN)
    moveValid && cDVec |-> ((cDMask >> moveDstIdx) & MAX_VL'(1)) != '0); // R3
  AST_SCALAR_SRC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    moveValid && !cSVec |-> moveSrcIdx == '0); // R5
  AST_SCALAR_DST_STOP: assert property (@(posedge clk) disable iff (!rstN)
    moveValid && !cDVec |-> done); // R6
  AST_REG_SUM: assert property (@(posedge clk) disable iff (!rstN)
    moveValid |-> (moveSrcReg == cSBase + REG_W'(moveSrcIdx)) &&
                  (moveDstReg == cDBase + REG_W'(moveDstIdx))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    moveValid |-> moveCount == $past(moveCount) + 1'b1); // R8
endmodule

bind twin_pred_mover twin_pred_mover_chk #(.MAX_VL(MAX_VL), .REG_W(REG_W), .IDX_W(IDX_W)) uChk (.*);

// File: tb/twin_pred_mover_tb.sv
module twin_pred_mover_tb;
  localparam int MAX_VL = 16;
  localparam int REG_W  = 7;
  localparam int IDX_W  = $clog2(MAX_VL + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IDX_W-1:0]  vlIn = '0;
  logic [MAX_VL-1:0] srcMask = '0, dstMask = '0;
  logic [REG_W-1:0]  srcBase = '0, dstBase = '0;
  logic srcIsVec = 1'b0, dstIsVec = 1'b0;
  logic busy, moveValid, done;
  logic [IDX_W-1:0] moveSrcIdx, moveDstIdx, moveCount;
  logic [REG_W-1:0] moveSrcReg, moveDstReg;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  twin_pred_mover #(.MAX_VL(MAX_VL), .REG_W(REG_W)) u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one operation and compares every move, the done timing and the count.
  task automatic runOp(input string req, input int vl, input logic [MAX_VL-1:0] sm,
                       input logic [MAX_VL-1:0] dm, input bit sv, input bit dv,
                       input bit poke);
    int expS[$], expD[$];
    int gotS[$], gotD[$];
    int ei = 0, ej = 0, evl, cycles = 0, doneCnt = 0, cnt = 0;
    bit lastWithDone = 0;
    evl = (vl > MAX_VL) ? MAX_VL : vl;
    while (ei < evl && ej < evl) begin
      if (sv) while (ei < evl && !sm[ei]) ei++;
      if (dv) while (ej < evl && !dm[ej]) ej++;
      if (ei >= evl || ej >= evl) break;
      expS.push_back(ei); expD.push_back(ej);
      if (sv) ei++;
      if (dv) ej++; else break;
    end
    @(negedge clk);
    vlIn = IDX_W'(vl); srcMask = sm; dstMask = dm;
    srcBase = 7'd120; dstBase = 7'd40; srcIsVec = sv; dstIsVec = dv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, req, "busy after start", int'(busy), 1);
    if (poke) begin
      start = 1'b1; srcMask = '1; dstMask = '1; vlIn = IDX_W'(MAX_VL);
      srcIsVec = 1'b1; dstIsVec = 1'b1;
    end
    while (doneCnt == 0 && cycles < 100) begin
      @(negedge clk);
      start = 1'b0;
      cycles++;
      if (moveValid) begin
        gotS.push_back(int'(moveSrcIdx)); gotD.push_back(int'(moveDstIdx));
        check(moveSrcReg == REG_W'(120 + int'(moveSrcIdx)), "R7", "src register",
              int'(moveSrcReg), (120 + int'(moveSrcIdx)) % 128);
        check(moveDstReg == REG_W'(40 + int'(moveDstIdx)), "R7", "dst register",
              int'(moveDstReg), 40 + int'(moveDstIdx));
        if (done) lastWithDone = 1;
      end
      if (done) begin
        doneCnt++;
        cnt = int'(moveCount);
        check(!busy, "R8", "busy low at done", int'(busy), 0);
      end
    end
    check(doneCnt == 1, req, "done seen", doneCnt, 1);
    check(gotS.size() == expS.size(), req, "move count observed", gotS.size(), expS.size());
    check(cnt == expS.size(), req, "moveCount at done (R8)", cnt, expS.size());
    for (int k = 0; k < expS.size() && k < gotS.size(); k++) begin
      check(gotS[k] == expS[k], req, "source index", gotS[k], expS[k]);
      check(gotD[k] == expD[k], req, "destination index", gotD[k], expD[k]);
    end
    if (!dv && expS.size() == 1)
      check(lastWithDone, "R6", "done with scalar-dest move", int'(lastWithDone), 1);
    @(negedge clk);
    check(!done && !busy, "R8", "done single pulse", int'(done), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !moveValid && !done && moveCount == 0, "R1", "reset state",
          int'(busy) + int'(moveValid) + int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    runOp("R10", 8, 16'h00A6, 16'hFFFF, 1, 1, 0);   // compress
    runOp("R10", 8, 16'hFFFF, 16'h0096, 1, 1, 0);   // expand
    runOp("R11", 5, 16'h0000, 16'hFFFF, 0, 1, 0);   // splat
    runOp("R11", 8, 16'h0020, 16'h0000, 1, 0, 0);   // select
    runOp("R11", 8, 16'h0000, 16'h0008, 0, 1, 0);   // insert
    runOp("R3",  12, 16'h0C51, 16'h0A2C, 1, 1, 0);  // twin walk, uneven
    runOp("R5",  16, 16'h8001, 16'h0F00, 1, 1, 0);  // source runs out first
    runOp("R4",  6, 16'h00F0, 16'h0003, 1, 1, 0);   // candidate beyond length
    runOp("R9",  0, 16'hFFFF, 16'hFFFF, 1, 1, 0);   // zero length
    runOp("R9",  9, 16'h0000, 16'hFFFF, 1, 1, 0);   // empty source mask
    runOp("R2",  31, 16'hFFFF, 16'hFFFF, 1, 1, 0);  // clamp to MAX_VL
    runOp("R6",  4, 16'h0000, 16'h0000, 0, 0, 0);   // scalar to scalar
    runOp("R2",  8, 16'h0011, 16'h0003, 1, 1, 1);   // start while busy ignored
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule